// File: doc/BRIEF.md
# Processor Heartbeat Supervisor

This block watches a set of worker processors through a single stream of heartbeat messages. Each message carries a valid strobe, a kind code and the identifier of the sending worker. A worker announces the start of a computation, then keeps proving it is alive with periodic beats. It closes the computation with a completion message. It may also report a failure it detected itself, or that it was reset.

For every worker the supervisor keeps a countdown timer, reloaded from a run-time programmable period, and a count of consecutive missed beats. When that count reaches a programmable limit, or when the worker reports a failure, the worker is declared faulty. The supervisor then issues one decision for it, either to restart the task on the same worker or to reassign it to another worker. A completion message produces a task-assign strobe for the next task on that worker. A reset notification produces an error-log strobe.

Top module: `hb_supervisor`

## Requirements
- R1: After reset every worker is idle and not faulty, and all outputs (fault flags, decision pulses, task-assign and error-log strobes) are zero.
- R2: A worker becomes busy when it sends a start message (kind 1). An idle worker is never timed out and never declared faulty.
- R3: A periodic beat (kind 0) from a busy worker reloads its timer from the period setting and clears its miss count, so a worker that beats at least every period+1 cycles is never declared faulty.
- R4: A busy worker without beats records one miss every period+1 cycles after its last reload. On the miss that brings the count to the limit (a limit of 0 acts as 1), its fault flag is set and exactly one decision pulse appears in the cycle after the clock edge that records that miss.
- R5: A failure message (kind 3) from a busy worker declares it faulty at once, with the decision pulse in the cycle after that message is sampled.
- R6: If reassignment is enabled and some other worker is idle and not faulty, the decision is a reassign pulse for the faulty worker. Its target field (bits w*ID_W upward of the target bus) holds the lowest-numbered such worker. Otherwise the decision is a restart pulse. The two pulses never occur together.
- R7: A completion message (kind 2) makes the worker idle and raises the task-assign strobe for one cycle, in the next cycle, carrying that worker's id.
- R8: A reset notification (kind 4) raises the error-log strobe for one cycle, in the next cycle, carrying the worker id. It leaves the worker's busy and fault state unchanged.
- R9: A start message clears the worker's fault flag.
- R10: Messages with kind codes 5 to 7 have no effect on any worker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_valid | input | 1 | Heartbeat message present this cycle |
| hb_kind | input | 3 | 0 periodic, 1 start, 2 completion, 3 failure, 4 reset notice |
| hb_id | input | ID_W | Sending worker |
| cfg_period | input | CNT_W | Timer reload value |
| cfg_miss_limit | input | MISS_W | Consecutive misses that declare a fault |
| cfg_reassign_en | input | 1 | Allow reassignment to an idle worker |
| fault_flags | output | N_WORKERS | Sticky fault flag per worker |
| restart_req | output | N_WORKERS | One-cycle restart decision per worker |
| reassign_req | output | N_WORKERS | One-cycle reassign decision per worker |
| reassign_tgt | output | N_WORKERS*ID_W | Target worker for each reassign decision |
| task_assign | output | 1 | Next-task strobe after a completion |
| task_assign_id | output | ID_W | Worker receiving the next task |
| reset_log | output | 1 | Error-log strobe for a reset notice |
| reset_log_id | output | ID_W | Worker that reported a reset |

## Verification
The assertions check on every cycle the properties that do not depend on timing. A declaration is always followed by exactly one kind of decision. Only a busy worker is ever declared. A failure from a busy worker declares it at once. A reassign never names the faulty worker itself. Completion and reset notices always yield their strobe with the right id. The scenarios of the bench are needed for what depends on history: the exact cycle of a timeout after a run of missed beats, and the fact that regular beats prevent it. They also show the choice of the lowest idle target, the clearing of a fault flag by a new start, and that reset notices and unused kinds leave the worker state alone.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [2:0] {
    HB_PERIODIC = 3'd0,
    HB_BEGIN    = 3'd1,
    HB_END      = 3'd2,
    HB_FAIL     = 3'd3,
    HB_RESET    = 3'd4
  } hb_kind_e;

  // A limit of zero behaves as a limit of one.
  function automatic logic limit_reached(input logic [31:0] misses,
                                         input logic [31:0] limit);
    logic [31:0] eff;
    eff = (limit == 32'd0) ? 32'd1 : limit;
    return misses >= eff;
  endfunction

endpackage

// File: rtl/hb_slot.sv
module hb_slot
  import hb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [2:0]        kind,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic [MISS_W-1:0] cfg_limit,
  output logic              busy,
  output logic              faulty,
  output logic              declare
);

  logic [CNT_W-1:0]  timer;
  logic [MISS_W-1:0] miss_cnt;
  logic start_ev, beat_ev, end_ev, fail_ev, miss_now, timeout_ev;

  assign start_ev   = hit && (kind == HB_BEGIN);
  assign beat_ev    = hit && (kind == HB_PERIODIC) && busy;
  assign end_ev     = hit && (kind == HB_END);
  assign fail_ev    = hit && (kind == HB_FAIL) && busy;
  assign miss_now   = busy && !(start_ev || beat_ev || end_ev) && (timer == '0);
  assign timeout_ev = miss_now &&
                      limit_reached(32'(miss_cnt) + 32'd1, 32'(cfg_limit));
  assign declare    = fail_ev || timeout_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      faulty   <= 1'b0;
      timer    <= '0;
      miss_cnt <= '0;
    end else if (start_ev) begin
      busy     <= 1'b1;
      faulty   <= 1'b0;
      timer    <= cfg_period;
      miss_cnt <= '0;
    end else if (declare) begin
      busy     <= 1'b0;
      faulty   <= 1'b1;
      miss_cnt <= '0;
    end else if (end_ev) begin
      busy     <= 1'b0;
      miss_cnt <= '0;
    end else if (beat_ev) begin
      timer    <= cfg_period;
      miss_cnt <= '0;
    end else if (busy) begin
      if (timer == '0) begin
        miss_cnt <= miss_cnt + 1'b1;
        timer    <= cfg_period;
      end else begin
        timer <= timer - 1'b1;
      end
    end
  end

endmodule

// File: rtl/hb_idle_pick.sv
module hb_idle_pick #(
  parameter int N_WORKERS = 4,
  parameter int ID_W      = 2
) (
  input  logic [N_WORKERS-1:0]      idle,
  output logic [N_WORKERS-1:0]      found,
  output logic [N_WORKERS*ID_W-1:0] tgt
);

  for (genvar w = 0; w < N_WORKERS; w++) begin : g_pick
    always_comb begin
      found[w] = 1'b0;
      tgt[w*ID_W +: ID_W] = '0;
      for (int j = N_WORKERS - 1; j >= 0; j--) begin
        if (idle[j] && (j != w)) begin
          found[w] = 1'b1;
          tgt[w*ID_W +: ID_W] = ID_W'(j);
        end
      end
    end
  end

endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
  import hb_pkg::*;
#(
  parameter int N_WORKERS = 4,
  parameter int CNT_W     = 16,
  parameter int MISS_W    = 4,
  parameter int ID_W      = (N_WORKERS > 1) ? $clog2(N_WORKERS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hb_valid,
  input  logic [2:0]                hb_kind,
  input  logic [ID_W-1:0]           hb_id,
  input  logic [CNT_W-1:0]          cfg_period,
  input  logic [MISS_W-1:0]         cfg_miss_limit,
  input  logic                      cfg_reassign_en,
  output logic [N_WORKERS-1:0]      fault_flags,
  output logic [N_WORKERS-1:0]      restart_req,
  output logic [N_WORKERS-1:0]      reassign_req,
  output logic [N_WORKERS*ID_W-1:0] reassign_tgt,
  output logic                      task_assign,
  output logic [ID_W-1:0]           task_assign_id,
  output logic                      reset_log,
  output logic [ID_W-1:0]           reset_log_id
);

  logic [N_WORKERS-1:0]      slot_hit, slot_busy, slot_faulty, slot_declare;
  logic [N_WORKERS-1:0]      idle_vec, pick_found, go_reassign;
  logic [N_WORKERS*ID_W-1:0] pick_tgt;
  logic                      id_ok;

  assign id_ok = int'(hb_id) < N_WORKERS;

  for (genvar w = 0; w < N_WORKERS; w++) begin : g_slot
    assign slot_hit[w] = hb_valid && (hb_id == ID_W'(w));
    hb_slot #(.CNT_W(CNT_W), .MISS_W(MISS_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (slot_hit[w]),
      .kind      (hb_kind),
      .cfg_period(cfg_period),
      .cfg_limit (cfg_miss_limit),
      .busy      (slot_busy[w]),
      .faulty    (slot_faulty[w]),
      .declare   (slot_declare[w])
    );
  end

  assign idle_vec    = ~slot_busy & ~slot_faulty;
  assign fault_flags = slot_faulty;

  hb_idle_pick #(.N_WORKERS(N_WORKERS), .ID_W(ID_W)) u_pick (
    .idle (idle_vec),
    .found(pick_found),
    .tgt  (pick_tgt)
  );

  assign go_reassign = slot_declare & pick_found & {N_WORKERS{cfg_reassign_en}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      restart_req    <= '0;
      reassign_req   <= '0;
      reassign_tgt   <= '0;
      task_assign    <= 1'b0;
      task_assign_id <= '0;
      reset_log      <= 1'b0;
      reset_log_id   <= '0;
    end else begin
      restart_req    <= slot_declare & ~go_reassign;
      reassign_req   <= go_reassign;
      reassign_tgt   <= pick_tgt;
      task_assign    <= hb_valid && id_ok && (hb_kind == HB_END);
      task_assign_id <= hb_id;
      reset_log      <= hb_valid && id_ok && (hb_kind == HB_RESET);
      reset_log_id   <= hb_id;
    end
  end

endmodule

// File: rtl/hb_supervisor_chk.sv
module hb_supervisor_chk
  import hb_pkg::*;
#(
  parameter int N_WORKERS = 4,
  parameter int ID_W      = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      hb_valid,
  input logic [2:0]                hb_kind,
  input logic [ID_W-1:0]           hb_id,
  input logic [N_WORKERS-1:0]      slot_busy,
  input logic [N_WORKERS-1:0]      slot_declare,
  input logic [N_WORKERS-1:0]      restart_req,
  input logic [N_WORKERS-1:0]      reassign_req,
  input logic [N_WORKERS*ID_W-1:0] reassign_tgt,
  input logic                      task_assign,
  input logic [ID_W-1:0]           task_assign_id,
  input logic                      reset_log,
  input logic [ID_W-1:0]           reset_log_id
);

  for (genvar w = 0; w < N_WORKERS; w++) begin : g_chk
    a_r6_single_decision: assert property (@(posedge clk) disable iff (!rst_n)
      !(restart_req[w] && reassign_req[w]));

    a_r4_decision_follows: assert property (@(posedge clk) disable iff (!rst_n)
      slot_declare[w] |=> (restart_req[w] || reassign_req[w]));

    a_r2_idle_not_declared: assert property (@(posedge clk) disable iff (!rst_n)
      slot_declare[w] |-> slot_busy[w]);

    a_r5_fail_declares: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_valid && hb_kind == HB_FAIL && hb_id == ID_W'(w) && slot_busy[w])
      |-> slot_declare[w]);

    a_r6_target_other: assert property (@(posedge clk) disable iff (!rst_n)
      reassign_req[w] |-> (reassign_tgt[w*ID_W +: ID_W] != ID_W'(w)));
  end

  a_r7_assign_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_valid && hb_kind == HB_END && int'(hb_id) < N_WORKERS)
    |=> (task_assign && task_assign_id == $past(hb_id)));

  a_r8_log_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_valid && hb_kind == HB_RESET && int'(hb_id) < N_WORKERS)
    |=> (reset_log && reset_log_id == $past(hb_id)));

endmodule

bind hb_supervisor hb_supervisor_chk #(.N_WORKERS(N_WORKERS), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hb_valid      (hb_valid),
  .hb_kind       (hb_kind),
  .hb_id         (hb_id),
  .slot_busy     (slot_busy),
  .slot_declare  (slot_declare),
  .restart_req   (restart_req),
  .reassign_req  (reassign_req),
  .reassign_tgt  (reassign_tgt),
  .task_assign   (task_assign),
  .task_assign_id(task_assign_id),
  .reset_log     (reset_log),
  .reset_log_id  (reset_log_id)
);

// File: tb/test_hb_supervisor.sv
`timescale 1ns/1ps
module test_hb_supervisor;

  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb_valid = 1'b0;
  logic [2:0] hb_kind = '0;
  logic [IW-1:0] hb_id = '0;
  logic [15:0] cfg_period = 16'd5;
  logic [3:0] cfg_miss_limit = 4'd3;
  logic cfg_reassign_en = 1'b0;
  logic [N-1:0] fault_flags, restart_req, reassign_req;
  logic [N*IW-1:0] reassign_tgt;
  logic task_assign, reset_log;
  logic [IW-1:0] task_assign_id, reset_log_id;

  always #2 clk = ~clk;

  hb_supervisor #(.N_WORKERS(N), .CNT_W(16), .MISS_W(4)) i_hb_supervisor (
    .clk(clk), .rst_n(rst_n), .hb_valid(hb_valid), .hb_kind(hb_kind), .hb_id(hb_id),
    .cfg_period(cfg_period), .cfg_miss_limit(cfg_miss_limit),
    .cfg_reassign_en(cfg_reassign_en), .fault_flags(fault_flags),
    .restart_req(restart_req), .reassign_req(reassign_req),
    .reassign_tgt(reassign_tgt), .task_assign(task_assign),
    .task_assign_id(task_assign_id), .reset_log(reset_log),
    .reset_log_id(reset_log_id)
  );

  typedef struct {
    int    due;
    int    ev;    // 0 restart, 1 reassign, 2 task, 3 log
    int    id;
    int    tgt;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(input int due, input int ev, input int id, input int tgt,
                      input string req);
    exp_t e;
    e.due = due; e.ev = ev; e.id = id; e.tgt = tgt; e.req = req;
    q.push_back(e);
  endtask

  task automatic observe(input int ev, input int id, input int tgt);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R2", $sformatf("unexpected event %0d id", ev), id, -1);
      return;
    end
    e = q.pop_front();
    check(e.ev == ev && e.id == id && e.tgt == tgt, e.req,
          $sformatf("event kind/id/tgt (%0d/%0d/%0d vs %0d/%0d/%0d)",
                    ev, id, tgt, e.ev, e.id, e.tgt), ev, e.ev);
    check(e.due == cyc, e.req, "event cycle", cyc, e.due);
  endtask

  // Monitor: compares produced pulses against the scoreboard.
  always @(negedge clk) begin
    if (mon_on) begin
      while (q.size() > 0 && q[0].due < cyc) begin
        check(1'b0, q[0].req, "missing event at cycle", cyc, q[0].due);
        void'(q.pop_front());
      end
      for (int w = 0; w < N; w++) if (restart_req[w]) observe(0, w, 0);
      for (int w = 0; w < N; w++)
        if (reassign_req[w]) observe(1, w, int'(reassign_tgt[w*IW +: IW]));
      if (task_assign) observe(2, int'(task_assign_id), 0);
      if (reset_log) observe(3, int'(reset_log_id), 0);
    end
  end

  // Drive one message; e returns the cycle where its registered result shows.
  task automatic send(input int k, input int id, output int e);
    @(negedge clk);
    hb_valid = 1'b1; hb_kind = 3'(k); hb_id = IW'(id);
    e = cyc + 1;
    @(posedge clk);
    #1 hb_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int e;
    int last;
    idle(3);
    // R1: state during and after reset
    check(fault_flags == 0 && restart_req == 0 && reassign_req == 0 &&
          !task_assign && !reset_log, "R1", "outputs in reset", 1, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    mon_on = 1'b1;
    check(fault_flags == 0 && restart_req == 0 && reassign_req == 0,
          "R1", "outputs after reset", int'(fault_flags), 0);

    // R2: idle workers are never timed out
    idle(100);
    check(q.size() == 0 && fault_flags == 0, "R2", "idle fault flags",
          int'(fault_flags), 0);

    // R3: worker 0 beats regularly, P=5 L=3, no fault
    send(1, 0, e);
    last = e;
    for (int i = 0; i < 15; i++) begin
      idle(3);
      send(0, 0, e);
      last = e;
    end
    idle(2);
    check(fault_flags == 0, "R3", "regular beats keep worker healthy",
          int'(fault_flags), 0);

    // R4: beats stop; restart on third miss (reassign disabled, R6)
    push(last + 3 * (5 + 1), 0, 0, 0, "R4");
    idle(25);
    check(fault_flags == 4'b0001, "R4", "fault flag after timeout",
          int'(fault_flags), 1);
    check(q.size() == 0, "R6", "restart issued with reassign off", q.size(), 0);

    // R9: new start clears the flag, then completion (R7)
    send(1, 0, e);
    idle(1);
    check(fault_flags == 0, "R9", "start clears fault", int'(fault_flags), 0);
    send(2, 0, e);
    push(e, 2, 0, 0, "R7");
    idle(3);

    // R5/R6: failure with reassign on, long period
    cfg_period = 16'd1000;
    cfg_reassign_en = 1'b1;
    send(1, 0, e);
    send(1, 1, e);
    send(3, 1, e);
    push(e, 1, 1, 2, "R6");
    idle(3);
    check(fault_flags == 4'b0010, "R5", "failure sets flag",
          int'(fault_flags), 2);
    send(1, 2, e);
    send(1, 3, e);
    send(3, 3, e);
    push(e, 0, 3, 0, "R6");
    idle(3);

    // R7: completion, then worker 0 is idle so a failure is ignored
    send(2, 0, e);
    push(e, 2, 0, 0, "R7");
    send(3, 0, e);
    idle(5);
    check(q.size() == 0 && fault_flags[0] == 1'b0, "R7",
          "worker idle after completion", int'(fault_flags[0]), 0);

    // R8: reset notice logged, worker 2 stays busy
    send(4, 2, e);
    push(e, 3, 2, 0, "R8");
    send(3, 2, e);
    push(e, 1, 2, 0, "R8");
    idle(3);

    // R10: unused kinds on idle worker 0 do not start it
    send(5, 0, e);
    send(7, 0, e);
    send(3, 0, e);
    idle(5);
    check(q.size() == 0 && fault_flags == 4'b1110, "R10",
          "unused kinds ignored", int'(fault_flags), 14);

    // R4 boundary: limit 1, period 2
    cfg_period = 16'd2;
    cfg_miss_limit = 4'd1;
    cfg_reassign_en = 1'b0;
    send(1, 0, e);
    push(e + 3, 0, 0, 0, "R4");
    idle(8);
    check(fault_flags == 4'b1111, "R4", "limit one fault flag",
          int'(fault_flags), 15);

    check(q.size() == 0, "R4", "scoreboard drained", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule